// File: doc/BRIEF.md
# Control Word Queue Controller

This block walks a circular ring of fixed-size command descriptors kept in system memory and feeds each one to a processing engine. Software programs four pointer registers: the bottom and top slots of the ring, the consumer index (head) and the producer index (tail). It then sets the enable bit in a control/status register. Each descriptor occupies eight 64-bit words, 64 bytes in all. Software queues work by moving the tail forward one slot at a time.

While enabled, the controller compares head against tail. If they differ, it reads the eight words of the descriptor at head through a valid/ready memory read port. It decodes the header word and the three address words, then offers the decoded job to the engine. When the engine signals completion, the controller steps head to the next slot. If the header asked for notification, it pulses an interrupt carrying the target strand number. A busy flag stays up while work is pending. A badly formed tail stops the controller with a protocol-error flag.

Top module: `cwq_ctrl`

## Requirements
- R1: After reset, every register reads zero: the status word and the first, last, head and tail pointers.
- R2: The registers are selected by reg_sel: 0 status, 1 first, 2 last, 3 head, 4 tail. Read data appears on reg_rdata one clock after reg_sel is presented. A pointer write keeps only the low 48 bits, so bits 63:48 read back as zero.
- R3: Status bits are: bit 0 enable, bit 1 busy, bit 2 terminated (always zero here), bit 3 protocol error. A status write loads enable from bit 0 of the write data and clears protocol error.
- R4: For the descriptor at head, the controller issues exactly eight read requests at head, head+8, up to head+0x38, in that order. A request that is not accepted keeps its valid and address unchanged.
- R5: The header word decodes as follows. Operation is bits 62:56. Start-of-block is bit 54 and end-of-block is bit 53. Interrupt request is bit 48 and strand is bits 39:37. Length (byte count minus one) is bits 23:0. The source address comes from word 1, the IV address from word 3 and the destination address from word 7, each truncated to its low 48 bits. Words 2, 4, 5 and 6 have no effect.
- R6: eng_valid stays high until eng_ready is seen. Exactly one engine job is produced per queued descriptor, and head moves only after eng_done.
- R7: On completion, head advances by 0x40. When head equals the last pointer, it becomes the first pointer instead.
- R8: Busy is high while enabled work is pending or in flight, and it drops once head equals tail. With head equal to tail, no fetch starts.
- R9: On completion of a descriptor whose interrupt bit is set, irq_valid pulses for one cycle with irq_strand equal to the strand field. Descriptors without the bit produce no pulse.
- R10: If head differs from tail and tail is not 64-byte aligned, or lies below first or above last, protocol error is set, busy is cleared, no read is issued and head is unchanged. The controller stays stopped until a status write clears the flag.
- R11: With enable low, no read request is issued and head does not move, even if tail differs from head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data for reg_sel |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 48 | Byte address of requested doubleword |
| mem_rsp_valid | input | 1 | Read data valid (in request order) |
| mem_rsp_data | input | 64 | Read data |
| eng_valid | output | 1 | Decoded job offered to the engine |
| eng_ready | input | 1 | Engine takes the job |
| eng_op | output | 7 | Operation code |
| eng_sob | output | 1 | Start-of-block flag |
| eng_eob | output | 1 | End-of-block flag |
| eng_len | output | 24 | Byte count minus one |
| eng_src | output | 48 | Source address |
| eng_iv | output | 48 | IV address |
| eng_dst | output | 48 | Destination address |
| eng_done | input | 1 | Engine finished the job |
| irq_valid | output | 1 | Completion interrupt pulse |
| irq_strand | output | 3 | Target strand of the interrupt |

## Verification
A wrong word counter or address register shows up on the very next accepted read as an address off the expected doubleword, and in the same descriptor as wrong engine fields. A faulty head step or wrap makes the next descriptor fetch from the wrong slot. It also leaves head unequal to tail after draining, so the status read never loses busy or the head readback mismatches. Protocol-error and disable faults show within a few cycles as stray read requests or a wrong status value.

// File: rtl/cwq_pkg.sv
package cwq_pkg;

  typedef enum logic [2:0] {
    SEL_CSR   = 3'd0,
    SEL_FIRST = 3'd1,
    SEL_LAST  = 3'd2,
    SEL_HEAD  = 3'd3,
    SEL_TAIL  = 3'd4
  } reg_sel_e;

  // descriptor word slots that carry information
  localparam int W_HDR = 0;
  localparam int W_SRC = 1;
  localparam int W_IV  = 3;
  localparam int W_DST = 7;

  // status bit positions
  localparam int CSR_EN   = 0;
  localparam int CSR_BUSY = 1;
  localparam int CSR_TERM = 2;
  localparam int CSR_PERR = 3;

  typedef struct packed {
    logic [6:0]  op;
    logic        sob;
    logic        eob;
    logic        irq;
    logic [2:0]  strand;
    logic [23:0] len;
  } cw_hdr_t;

  function automatic cw_hdr_t decode_hdr(input logic [63:0] w);
    cw_hdr_t h;
    h.op     = w[62:56];
    h.sob    = w[54];
    h.eob    = w[53];
    h.irq    = w[48];
    h.strand = w[39:37];
    h.len    = w[23:0];
    return h;
  endfunction

endpackage

// File: rtl/cwq_regs.sv
module cwq_regs
  import cwq_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 48,
  parameter int ENTRY_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              adv_head,
  input  logic              set_perr,
  input  logic              busy,
  output logic [ADDR_W-1:0] first,
  output logic [ADDR_W-1:0] last,
  output logic [ADDR_W-1:0] head,
  output logic [ADDR_W-1:0] tail,
  output logic              en,
  output logic              perr,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ENTRY_BYTES);

  logic wdata_unused;
  assign wdata_unused = ^wdata[DATA_W-1:ADDR_W];

  logic [3:0] csr_bits;
  always_comb begin
    csr_bits           = '0;
    csr_bits[CSR_EN]   = en;
    csr_bits[CSR_BUSY] = busy;
    csr_bits[CSR_TERM] = 1'b0;
    csr_bits[CSR_PERR] = perr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first <= '0;
      last  <= '0;
      head  <= '0;
      tail  <= '0;
      en    <= 1'b0;
      perr  <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr_en) begin
        case (reg_sel_e'(sel))
          SEL_CSR: begin
            en   <= wdata[CSR_EN];
            perr <= 1'b0;
          end
          SEL_FIRST: first <= wdata[ADDR_W-1:0];
          SEL_LAST:  last  <= wdata[ADDR_W-1:0];
          SEL_HEAD:  head  <= wdata[ADDR_W-1:0];
          SEL_TAIL:  tail  <= wdata[ADDR_W-1:0];
          default: ;
        endcase
      end
      if (set_perr) perr <= 1'b1;
      if (adv_head) head <= (head == last) ? first : head + STEP;
      case (reg_sel_e'(sel))
        SEL_CSR:   rdata <= DATA_W'(csr_bits);
        SEL_FIRST: rdata <= DATA_W'(first);
        SEL_LAST:  rdata <= DATA_W'(last);
        SEL_HEAD:  rdata <= DATA_W'(head);
        SEL_TAIL:  rdata <= DATA_W'(tail);
        default:   rdata <= '0;
      endcase
    end
  end

  // R7
  head_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_head && !wr_en && head == last) |=> (head == $past(first)));

  // R10
  perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (perr && !(wr_en && sel == SEL_CSR)) |=> perr);

endmodule

// File: rtl/cwq_fetch.sv
module cwq_fetch
  import cwq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 48,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic [DATA_W-1:0] hdr_word,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] iv_addr,
  output logic [ADDR_W-1:0] dst_addr
);

  localparam int CNT_W = $clog2(WORDS + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0] req_cnt;
  logic [CNT_W-1:0] rsp_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_cnt   <= '0;
      rsp_cnt   <= '0;
      done      <= 1'b0;
      hdr_word  <= '0;
      src_addr  <= '0;
      iv_addr   <= '0;
      dst_addr  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        req_valid <= 1'b1;
        req_addr  <= base;
        req_cnt   <= '0;
        rsp_cnt   <= '0;
      end else if (req_valid && req_ready) begin
        req_cnt <= req_cnt + 1'b1;
        if (req_cnt == LAST_IDX) req_valid <= 1'b0;
        else                     req_addr  <= req_addr + STEP;
      end
      if (rsp_valid && !start) begin
        if (rsp_cnt == CNT_W'(W_HDR)) hdr_word <= rsp_data;
        if (rsp_cnt == CNT_W'(W_SRC)) src_addr <= rsp_data[ADDR_W-1:0];
        if (rsp_cnt == CNT_W'(W_IV))  iv_addr  <= rsp_data[ADDR_W-1:0];
        if (rsp_cnt == CNT_W'(W_DST)) dst_addr <= rsp_data[ADDR_W-1:0];
        rsp_cnt <= rsp_cnt + 1'b1;
        if (rsp_cnt == LAST_IDX) done <= 1'b1;
      end
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !start) |=> (req_valid && $stable(req_addr)));

  // R4
  req_count_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> (req_cnt < CNT_W'(WORDS)));

endmodule

// File: rtl/cwq_seq.sv
module cwq_seq
  import cwq_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int ENTRY_BYTES = 64,
  parameter int STRAND_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                perr,
  input  logic [ADDR_W-1:0]   first,
  input  logic [ADDR_W-1:0]   last,
  input  logic [ADDR_W-1:0]   head,
  input  logic [ADDR_W-1:0]   tail,
  input  logic                fetch_done,
  input  logic                hdr_irq,
  input  logic [STRAND_W-1:0] hdr_strand,
  input  logic                eng_ready,
  input  logic                eng_done,
  output logic                fetch_start,
  output logic                busy,
  output logic                set_perr,
  output logic                adv_head,
  output logic                eng_valid,
  output logic                irq_valid,
  output logic [STRAND_W-1:0] irq_strand
);

  localparam int ALIGN_W = $clog2(ENTRY_BYTES);

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_ISSUE, ST_WAIT, ST_SETTLE} st_e;
  st_e state;

  logic tail_bad;
  logic pending;
  assign tail_bad = (|tail[ALIGN_W-1:0]) || (tail < first) || (tail > last);
  assign pending  = en && !perr && (head != tail);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      fetch_start <= 1'b0;
      busy        <= 1'b0;
      set_perr    <= 1'b0;
      adv_head    <= 1'b0;
      eng_valid   <= 1'b0;
      irq_valid   <= 1'b0;
      irq_strand  <= '0;
    end else begin
      fetch_start <= 1'b0;
      set_perr    <= 1'b0;
      adv_head    <= 1'b0;
      irq_valid   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (pending && tail_bad) begin
            set_perr <= 1'b1;
            busy     <= 1'b0;
          end else if (pending) begin
            fetch_start <= 1'b1;
            busy        <= 1'b1;
            state       <= ST_FETCH;
          end else begin
            busy <= 1'b0;
          end
        end
        ST_FETCH: begin
          if (fetch_done) begin
            eng_valid <= 1'b1;
            state     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (eng_ready) begin
            eng_valid <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (eng_done) begin
            adv_head   <= 1'b1;
            irq_valid  <= hdr_irq;
            irq_strand <= hdr_strand;
            state      <= ST_SETTLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  eng_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !eng_ready) |=> eng_valid);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |=> !irq_valid);

  // R8
  empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && head == tail) |=> (!busy && !fetch_start));

  // R11
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !en) |=> !fetch_start);

endmodule

// File: rtl/cwq_ctrl.sv
module cwq_ctrl
  import cwq_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 48,
  parameter int WORDS    = 8,
  parameter int STRAND_W = 3,
  parameter int OP_W     = 7,
  parameter int LEN_W    = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [2:0]          reg_sel,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ADDR_W-1:0]   mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_data,
  output logic                eng_valid,
  input  logic                eng_ready,
  output logic [OP_W-1:0]     eng_op,
  output logic                eng_sob,
  output logic                eng_eob,
  output logic [LEN_W-1:0]    eng_len,
  output logic [ADDR_W-1:0]   eng_src,
  output logic [ADDR_W-1:0]   eng_iv,
  output logic [ADDR_W-1:0]   eng_dst,
  input  logic                eng_done,
  output logic                irq_valid,
  output logic [STRAND_W-1:0] irq_strand
);

  localparam int ENTRY_BYTES = WORDS * (DATA_W / 8);

  logic [ADDR_W-1:0] first, last, head, tail;
  logic en, perr, busy, adv_head, set_perr, fetch_start, fetch_done;
  logic [DATA_W-1:0] hdr_word;
  cw_hdr_t hdr;
  logic hdr_unused;

  assign hdr        = decode_hdr(64'(hdr_word));
  assign hdr_unused = ^hdr_word;
  assign eng_op     = OP_W'(hdr.op);
  assign eng_sob    = hdr.sob;
  assign eng_eob    = hdr.eob;
  assign eng_len    = LEN_W'(hdr.len);

  cwq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .adv_head(adv_head), .set_perr(set_perr), .busy(busy),
    .first(first), .last(last), .head(head), .tail(tail),
    .en(en), .perr(perr), .rdata(reg_rdata)
  );

  cwq_fetch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) u_fetch (
    .clk(clk), .rst(rst), .start(fetch_start), .base(head),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .done(fetch_done), .hdr_word(hdr_word),
    .src_addr(eng_src), .iv_addr(eng_iv), .dst_addr(eng_dst)
  );

  cwq_seq #(.ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES), .STRAND_W(STRAND_W)) u_seq (
    .clk(clk), .rst(rst), .en(en), .perr(perr),
    .first(first), .last(last), .head(head), .tail(tail),
    .fetch_done(fetch_done), .hdr_irq(hdr.irq), .hdr_strand(STRAND_W'(hdr.strand)),
    .eng_ready(eng_ready), .eng_done(eng_done),
    .fetch_start(fetch_start), .busy(busy), .set_perr(set_perr), .adv_head(adv_head),
    .eng_valid(eng_valid), .irq_valid(irq_valid), .irq_strand(irq_strand)
  );

  // R10
  perr_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    perr |-> !fetch_start);

endmodule

// File: tb/test_cwq_ctrl.sv
module test_cwq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] QF = 48'h1000;
  localparam logic [47:0] QL = 48'h10C0;

  logic clk = 0, rst = 1;
  logic reg_wr = 0;
  logic [2:0] reg_sel = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [47:0] mem_req_addr;
  logic [63:0] mem_rsp_data = 0;
  logic eng_valid, eng_ready = 0, eng_sob, eng_eob, eng_done = 0;
  logic [6:0] eng_op;
  logic [23:0] eng_len;
  logic [47:0] eng_src, eng_iv, eng_dst;
  logic irq_valid;
  logic [2:0] irq_strand;

  int total = 0, fails = 0, cyc = 0, dcnt = 0;
  int ridx = 0, req_total = 0, irq_seen = 0, done_seen = 0;
  logic [47:0] exp_head = QF, exp_cur = QF, tail_m = QF;
  bit ended = 0;

  cwq_ctrl i_cwq_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_op(eng_op), .eng_sob(eng_sob),
    .eng_eob(eng_eob), .eng_len(eng_len), .eng_src(eng_src), .eng_iv(eng_iv),
    .eng_dst(eng_dst), .eng_done(eng_done), .irq_valid(irq_valid), .irq_strand(irq_strand)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [47:0] nxt(input logic [47:0] p);
    return (p == QL) ? QF : p + 48'h40;
  endfunction

  function automatic logic [63:0] hdr_of(input logic [47:0] e);
    return {1'b1, 7'h41 + 7'(e[8:6]), 1'b1, 1'b1, e[7], 4'b0, e[6], 8'h0,
            e[8:6] ^ 3'b101, 13'b0, 24'(e[11:0]) + 24'h1D};
  endfunction

  function automatic logic [63:0] mword(input logic [47:0] a);
    logic [47:0] e;
    e = {a[47:6], 6'b0};
    case (a[5:3])
      3'd0: return hdr_of(e);
      3'd1: return {16'hC0DE, e + 48'h100000};
      3'd3: return {16'hBEEF, e + 48'h200000};
      3'd7: return {16'hF00D, e + 48'h300000};
      default: return {16'hA5A5, 48'hFFFF_FFFF_0000} | 64'(a);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // memory and engine models, back-pressure patterns
  always @(negedge clk) begin
    mem_req_ready = (cyc % 3) != 2;
    eng_ready     = (cyc % 4) == 1;
  end
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mword(mem_req_addr);
    eng_done <= 1'b0;
    if (dcnt != 0) begin
      dcnt <= dcnt - 1;
      if (dcnt == 1) eng_done <= 1'b1;
    end else if (eng_valid && eng_ready) dcnt <= 3;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // port monitor
  always @(negedge clk) if (!rst) begin
    if (mem_req_valid && mem_req_ready) begin
      chk(mem_req_addr == exp_head + 48'(8 * ridx), "R4 read address", 64'(mem_req_addr),
          64'(exp_head + 48'(8 * ridx)));
      ridx++; req_total++;
    end
    if (eng_valid && eng_ready) begin
      logic [63:0] h;
      h = hdr_of(exp_head);
      chk(ridx == 8, "R4 eight reads per entry", 64'(ridx), 64'd8);
      chk({eng_op, eng_sob, eng_eob, eng_len} == {h[62:56], h[54], h[53], h[23:0]},
          "R5 header fields", 64'({eng_op, eng_sob, eng_eob, eng_len}),
          64'({h[62:56], h[54], h[53], h[23:0]}));
      chk(eng_src == exp_head + 48'h100000, "R5 source", 64'(eng_src), 64'(exp_head + 48'h100000));
      chk(eng_iv == exp_head + 48'h200000, "R5 iv", 64'(eng_iv), 64'(exp_head + 48'h200000));
      chk(eng_dst == exp_head + 48'h300000, "R5 destination", 64'(eng_dst), 64'(exp_head + 48'h300000));
      exp_cur = exp_head;
      ridx = 0;
    end
    if (eng_done) begin
      exp_head = nxt(exp_head);
      done_seen++;
    end
    if (irq_valid) begin
      chk(exp_cur[6] == 1'b1, "R9 irq only when requested", 64'(irq_valid), 64'(exp_cur[6]));
      chk(irq_strand == (exp_cur[8:6] ^ 3'b101), "R9 strand", 64'(irq_strand),
          64'(exp_cur[8:6] ^ 3'b101));
      irq_seen++;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [63:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [63:0] v);
    reg_sel = s;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic drain();
    logic [63:0] v;
    repeat (4) @(negedge clk);
    rd(3'd0, v);
    chk(v[1] == 1'b1, "R8 busy while pending", v, 64'h3);
    for (int i = 0; i < 2000; i++) begin
      rd(3'd0, v);
      if (v[1] == 1'b0) break;
    end
    chk(v == 64'h1, "R8 busy drops when drained", v, 64'h1);
  endtask

  initial begin
    logic [63:0] v;
    logic [47:0] x;
    int rb, db, ib, iexp;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v);
      chk(v == 0, "R1 reset value", v, 64'h0);
    end
    for (int s = 1; s < 5; s++) begin
      logic [63:0] d;
      d = {16'hFFF0 | 16'(s), 48'h1234_5678_9A00 + 48'(s * 64)};
      wr(3'(s), d);
      rd(3'(s), v);
      chk(v == {16'h0, d[47:0]}, "R2 pointer truncation", v, {16'h0, d[47:0]});
    end
    wr(3'd1, 64'(QF)); wr(3'd2, 64'(QL)); wr(3'd3, 64'(QF)); wr(3'd4, 64'(QF));
    wr(3'd0, 64'h1);
    repeat (5) @(negedge clk);
    rd(3'd0, v);
    chk(v == 64'h1, "R3 R8 enabled and idle on empty queue", v, 64'h1);
    chk(req_total == 0, "R8 no fetch on empty queue", 64'(req_total), 64'h0);

    for (int r = 0; r < 9; r++) begin
      int n;
      n = (r % 3) + 1; iexp = 0;
      for (int k = 0; k < n; k++) begin
        if (tail_m[6]) iexp++;
        tail_m = nxt(tail_m);
      end
      db = done_seen; ib = irq_seen;
      wr(3'd4, 64'(tail_m));
      drain();
      rd(3'd3, v);
      chk(v == 64'(tail_m), "R7 head reaches tail with wrap", v, 64'(tail_m));
      chk(done_seen - db == n, "R6 one job per entry", 64'(done_seen - db), 64'(n));
      chk(irq_seen - ib == iexp, "R9 interrupt count", 64'(irq_seen - ib), 64'(iexp));
    end

    // disabled controller
    wr(3'd0, 64'h0);
    rd(3'd0, v);
    chk(v == 64'h0, "R3 enable cleared", v, 64'h0);
    rb = req_total; x = exp_head;
    tail_m = nxt(tail_m);
    wr(3'd4, 64'(tail_m));
    repeat (20) @(negedge clk);
    chk(req_total == rb, "R11 no reads while disabled", 64'(req_total), 64'(rb));
    rd(3'd3, v);
    chk(v == 64'(x), "R11 head unchanged while disabled", v, 64'(x));
    wr(3'd0, 64'h1);
    drain();
    rd(3'd3, v);
    chk(v == 64'(tail_m), "R11 resumes after enable", v, 64'(tail_m));

    // malformed tail values
    x = tail_m; rb = req_total;
    wr(3'd4, 64'(x + 48'h4));
    repeat (6) @(negedge clk);
    rd(3'd0, v);
    chk(v == 64'h9, "R10 misaligned tail", v, 64'h9);
    wr(3'd4, 64'(QL + 48'h40)); wr(3'd0, 64'h1);
    repeat (6) @(negedge clk);
    rd(3'd0, v);
    chk(v == 64'h9, "R10 tail above last", v, 64'h9);
    wr(3'd4, 64'(QF - 48'h40)); wr(3'd0, 64'h1);
    repeat (6) @(negedge clk);
    rd(3'd0, v);
    chk(v == 64'h9, "R10 tail below first", v, 64'h9);
    wr(3'd4, 64'(x + 48'h40));
    repeat (6) @(negedge clk);
    rd(3'd0, v);
    chk(v == 64'h9, "R10 stays stopped until status write", v, 64'h9);
    chk(req_total == rb, "R10 no reads on error", 64'(req_total), 64'(rb));
    rd(3'd3, v);
    chk(v == 64'(x), "R10 head unchanged", v, 64'(x));
    wr(3'd4, 64'(x)); wr(3'd0, 64'h1);
    repeat (4) @(negedge clk);
    rd(3'd0, v);
    chk(v == 64'h1, "R3 status write clears error", v, 64'h1);
    tail_m = nxt(x);
    wr(3'd4, 64'(tail_m));
    drain();
    rd(3'd3, v);
    chk(v == 64'(tail_m), "R10 recovers after clear", v, 64'(tail_m));
    finish_run();
  end
endmodule